// File: doc/BRIEF.md
# Print Sequence Timing Controller

This block runs one print cycle for an inkjet fire-pulse generator. A host raises a print strobe. If the strobe's width is legal and the controller is free, the strobe is accepted. The controller then pulls its active-low busy line down and closes the data window for a short interval, after which the host may start shifting data for the next cycle. After a fixed lead time it plays four back-to-back fire pulses, numbered 0 to 3. Each pulse has its own programmable length. A start marker and an end marker tell the waveform generator where each pulse begins and ends.

The busy line is released a fixed number of cycles before pulse 3 ends. The next strobe can therefore be accepted while the current sequence finishes, and the tail of the old pulse 3 is not disturbed. A fault input stops the pulses at once and locks the controller until reset. Every time is a parameter counted in system clock cycles. The defaults assume a 100 MHz clock: strobe width 70 ns to 1 us, data window 300 ns, lead time 13.8 us, early release 3.5 us, pulse floor 10 us. All inputs are synchronous to `clk`.

Top module: `print_seq_ctrl`

## Requirements
- R1: While and right after reset, `busy_n_o` and `data_win_o` are 1, and `fire_o`, `pulse_start_o` and `pulse_end_o` are 0.
- R2: A strobe is judged in the first cycle `print_i` is sampled low after being high. It is accepted only if it was high for STROBE_MIN to STROBE_MAX sampled cycles, inclusive. On acceptance `busy_n_o` is 0 from the next cycle.
- R3: A strobe is ignored if `busy_n_o` was 0 in any cycle in which it was sampled high, or in its judging cycle.
- R4: `data_win_o` goes to 0 in the cycle after acceptance and returns to 1 DATA_DELAY cycles after acceptance.
- R5: `fire_o` rises FIRE_DELAY cycles after acceptance. Four pulses follow with no gap between them, and `pulse_idx_o` shows 0, 1, 2, 3 in turn.
- R6: Pulse k lasts the number of cycles in `dur_i[k*DUR_W +: DUR_W]`, sampled in the acceptance cycle. A value below PULSE_MIN is raised to PULSE_MIN.
- R7: `pulse_start_o` is 1 in only the first cycle of each pulse, and `pulse_end_o` is 1 in only its last cycle.
- R8: `busy_n_o` returns to 1 exactly EARLY_REL cycles before `fire_o` falls after pulse 3. A strobe accepted from then on leaves the running pulse 3 unchanged.
- R9: When `fault_i` is sampled 1, `fire_o` is 0 from the next cycle on. `busy_n_o` then stays 0 and every strobe is ignored until reset.

Parameter constraints: DATA_DELAY < FIRE_DELAY, 1 <= EARLY_REL < PULSE_MIN, and EARLY_REL < FIRE_DELAY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| print_i | input | 1 | Print strobe, active high |
| fault_i | input | 1 | Fault request, aborts and locks |
| dur_i | input | 4*DUR_W | Pulse lengths in cycles, pulse k in field k |
| busy_n_o | output | 1 | Busy, active low |
| data_win_o | output | 1 | Host may send next data |
| fire_o | output | 1 | A fire pulse is active |
| pulse_idx_o | output | 2 | Index of the active pulse |
| pulse_start_o | output | 1 | First cycle of a pulse |
| pulse_end_o | output | 1 | Last cycle of a pulse |

## Verification
A wrong lead counter shows as `fire_o` rising on the wrong cycle, or as `data_win_o` reopening on the wrong cycle. Either is visible within one sequence. A wrong remaining-length counter or pulse index shifts the start and end markers of the very next pulse, and it moves the release of `busy_n_o`. A bad strobe-width counter or taint flag shows up as a whole sequence that should not exist, or one that is missing, so the outputs differ for thousands of cycles. Every output is compared on every cycle, which places each error within one clock of its first visible effect.

// File: rtl/print_seq_pkg.sv
package print_seq_pkg;
  localparam int NPULSE = 4;
  localparam int IDX_W  = 2;

  // raise a programmed length to the floor
  function automatic logic [31:0] clamp_up(input logic [31:0] v, input logic [31:0] floor_v);
    return (v < floor_v) ? floor_v : v;
  endfunction

  // inclusive width window for strobe qualification
  function automatic logic in_window(input logic [31:0] w, input logic [31:0] lo, input logic [31:0] hi);
    return (w >= lo) && (w <= hi);
  endfunction
endpackage

// File: rtl/pseq_strobe_qual.sv
module pseq_strobe_qual #(
  parameter int STROBE_MIN = 7,
  parameter int STROBE_MAX = 100
) (
  input  logic clk,
  input  logic rst_n,
  input  logic print_i,
  input  logic busy_low_i,
  input  logic inhibit_i,
  output logic accept_o
);
  import print_seq_pkg::*;
  localparam int CW = $clog2(STROBE_MAX + 2);
  localparam logic [CW-1:0] SAT = CW'(STROBE_MAX + 1);

  logic          prev_q, taint_q;
  logic [CW-1:0] wcnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= 1'b0;
      taint_q <= 1'b0;
      wcnt_q  <= '0;
    end else begin
      prev_q <= print_i;
      if (print_i) begin
        taint_q <= (prev_q & taint_q) | busy_low_i;
        if (!prev_q)           wcnt_q <= CW'(1);
        else if (wcnt_q != SAT) wcnt_q <= wcnt_q + 1'b1;
      end
    end
  end

  assign accept_o = prev_q && !print_i && !taint_q && !busy_low_i && !inhibit_i &&
                    in_window(32'(wcnt_q), 32'(STROBE_MIN), 32'(STROBE_MAX));
endmodule

// File: rtl/pseq_lead_timer.sv
module pseq_lead_timer #(
  parameter int FIRE_DELAY = 1380,
  parameter int DATA_DELAY = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic abort_i,
  output logic win_open_o,
  output logic fire_go_o
);
  localparam int LW = $clog2(FIRE_DELAY + 1);
  localparam logic [LW-1:0] LAST = LW'(FIRE_DELAY - 1);

  logic          lead_on_q;
  logic [LW-1:0] lead_cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lead_on_q  <= 1'b0;
      lead_cnt_q <= '0;
    end else if (abort_i) begin
      lead_on_q <= 1'b0;
    end else if (start_i) begin
      lead_on_q  <= 1'b1;
      lead_cnt_q <= '0;
    end else if (lead_on_q) begin
      if (lead_cnt_q == LAST) lead_on_q <= 1'b0;
      else                    lead_cnt_q <= lead_cnt_q + 1'b1;
    end
  end

  assign fire_go_o  = lead_on_q && (lead_cnt_q == LAST) && !abort_i;
  assign win_open_o = !(lead_on_q && (lead_cnt_q < LW'(DATA_DELAY)));
endmodule

// File: rtl/pseq_fire_engine.sv
module pseq_fire_engine #(
  parameter int DUR_W     = 16,
  parameter int EARLY_REL = 350
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go_i,
  input  logic abort_i,
  input  logic [print_seq_pkg::NPULSE-1:0][DUR_W-1:0] dur_i,
  output logic fire_o,
  output logic [print_seq_pkg::IDX_W-1:0] idx_o,
  output logic start_o,
  output logic end_o,
  output logic release_o
);
  import print_seq_pkg::*;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NPULSE - 1);
  localparam logic [DUR_W-1:0] REL_AT   = DUR_W'(EARLY_REL + 1);

  logic             fire_q, start_q;
  logic [IDX_W-1:0] idx_q, nidx;
  logic [DUR_W-1:0] rem_q;

  assign nidx = idx_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fire_q  <= 1'b0;
      start_q <= 1'b0;
      idx_q   <= '0;
      rem_q   <= '0;
    end else if (abort_i) begin
      fire_q  <= 1'b0;
      start_q <= 1'b0;
    end else if (go_i) begin
      fire_q  <= 1'b1;
      start_q <= 1'b1;
      idx_q   <= '0;
      rem_q   <= dur_i[0];
    end else if (fire_q) begin
      if (rem_q == DUR_W'(1)) begin
        if (idx_q == LAST_IDX) begin
          fire_q  <= 1'b0;
          start_q <= 1'b0;
        end else begin
          idx_q   <= nidx;
          rem_q   <= dur_i[nidx];
          start_q <= 1'b1;
        end
      end else begin
        rem_q   <= rem_q - 1'b1;
        start_q <= 1'b0;
      end
    end else begin
      start_q <= 1'b0;
    end
  end

  assign fire_o    = fire_q;
  assign idx_o     = idx_q;
  assign start_o   = start_q;
  assign end_o     = fire_q && (rem_q == DUR_W'(1));
  assign release_o = fire_q && (idx_q == LAST_IDX) && (rem_q == REL_AT);
endmodule

// File: rtl/print_seq_ctrl.sv
module print_seq_ctrl #(
  parameter int STROBE_MIN = 7,
  parameter int STROBE_MAX = 100,
  parameter int FIRE_DELAY = 1380,
  parameter int DATA_DELAY = 30,
  parameter int EARLY_REL  = 350,
  parameter int PULSE_MIN  = 1000,
  parameter int DUR_W      = 16
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  print_i,
  input  logic                                  fault_i,
  input  logic [print_seq_pkg::NPULSE*DUR_W-1:0] dur_i,
  output logic                                  busy_n_o,
  output logic                                  data_win_o,
  output logic                                  fire_o,
  output logic [print_seq_pkg::IDX_W-1:0]       pulse_idx_o,
  output logic                                  pulse_start_o,
  output logic                                  pulse_end_o
);
  import print_seq_pkg::*;

  logic busy_q, fault_q;
  logic accept_w, fire_go_w, release_w, busy_low_w;
  logic [NPULSE-1:0][DUR_W-1:0] bank_q;

  assign busy_low_w = busy_q | fault_q;

  pseq_strobe_qual #(.STROBE_MIN(STROBE_MIN), .STROBE_MAX(STROBE_MAX)) u_qual (
    .clk(clk), .rst_n(rst_n), .print_i(print_i),
    .busy_low_i(busy_low_w), .inhibit_i(fault_q | fault_i), .accept_o(accept_w)
  );

  pseq_lead_timer #(.FIRE_DELAY(FIRE_DELAY), .DATA_DELAY(DATA_DELAY)) u_lead (
    .clk(clk), .rst_n(rst_n), .start_i(accept_w), .abort_i(fault_i),
    .win_open_o(data_win_o), .fire_go_o(fire_go_w)
  );

  pseq_fire_engine #(.DUR_W(DUR_W), .EARLY_REL(EARLY_REL)) u_fire (
    .clk(clk), .rst_n(rst_n), .go_i(fire_go_w), .abort_i(fault_i), .dur_i(bank_q),
    .fire_o(fire_o), .idx_o(pulse_idx_o), .start_o(pulse_start_o),
    .end_o(pulse_end_o), .release_o(release_w)
  );

  for (genvar k = 0; k < NPULSE; k++) begin : g_bank
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        bank_q[k] <= DUR_W'(PULSE_MIN);
      else if (accept_w) bank_q[k] <= DUR_W'(clamp_up(32'(dur_i[k*DUR_W +: DUR_W]), 32'(PULSE_MIN)));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      if (fault_i)        fault_q <= 1'b1;
      if (accept_w)       busy_q  <= 1'b1;
      else if (release_w) busy_q  <= 1'b0;
    end
  end

  assign busy_n_o = !busy_low_w;
endmodule

// File: rtl/print_seq_ctrl_chk.sv
module print_seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       fault_i,
  input logic       accept_w,
  input logic       busy_n_o,
  input logic       data_win_o,
  input logic       fire_o,
  input logic [1:0] pulse_idx_o,
  input logic       pulse_start_o,
  input logic       pulse_end_o
);
  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> !busy_n_o);
  assert_no_accept_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n_o |-> !accept_w);
  assert_win_closes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |=> !data_win_o);
  assert_idx_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_end_o && pulse_idx_o != 2'd3 && !fault_i) |=>
      (fire_o && pulse_start_o && pulse_idx_o == $past(pulse_idx_o) + 2'd1));
  assert_start_in_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_start_o |-> fire_o);
  assert_end_in_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_end_o |-> fire_o);
  assert_fault_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fault_i |=> (!fire_o && !busy_n_o));
endmodule

bind print_seq_ctrl print_seq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .fault_i(fault_i), .accept_w(accept_w),
  .busy_n_o(busy_n_o), .data_win_o(data_win_o), .fire_o(fire_o),
  .pulse_idx_o(pulse_idx_o), .pulse_start_o(pulse_start_o), .pulse_end_o(pulse_end_o)
);

// File: tb/test_print_seq_ctrl.sv
`timescale 1ns/1ps
module test_print_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SMIN = 2, SMAX = 6, FD = 20, DD = 3, ER = 4, PMIN = 8, DW = 8;
  localparam int FAR = -1000000;

  logic clk = 1'b0, rst_n = 1'b0, print_i = 1'b0, fault_i = 1'b0;
  logic [4*DW-1:0] dur_i = '0;
  logic busy_n_o, data_win_o, fire_o, pulse_start_o, pulse_end_o;
  logic [1:0] pulse_idx_o;

  int tests = 0, fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  print_seq_ctrl #(.STROBE_MIN(SMIN), .STROBE_MAX(SMAX), .FIRE_DELAY(FD), .DATA_DELAY(DD),
                   .EARLY_REL(ER), .PULSE_MIN(PMIN), .DUR_W(DW)) i_print_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .print_i(print_i), .fault_i(fault_i), .dur_i(dur_i),
    .busy_n_o(busy_n_o), .data_win_o(data_win_o), .fire_o(fire_o),
    .pulse_idx_o(pulse_idx_o), .pulse_start_o(pulse_start_o), .pulse_end_o(pulse_end_o));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: edge count, sequence boundary lists, fault time
  int n = 0, ta = FAR, tf = 1 << 30, ph = 0;
  bit prev = 0, taint = 0;
  int cur_b[5], old_b[5];

  function automatic bit busylow(int k);
    return (tf <= k) || (k >= ta && k < cur_b[4] - ER);
  endfunction

  function automatic int seq_idx(int k, int b[5]);
    for (int i = 0; i < 4; i++) if (k >= b[i] && k < b[i+1]) return i;
    return -1;
  endfunction

  always @(posedge clk) begin
    n++;
    if (!rst_n) begin
      ta = FAR; tf = 1 << 30; ph = 0; prev = 0; taint = 0;
      for (int i = 0; i < 5; i++) begin cur_b[i] = FAR; old_b[i] = FAR; end
    end else begin
      bit bprev, acc;
      bprev = busylow(n - 1);
      acc = 0;
      if (print_i) begin
        taint = (prev ? taint : 1'b0) | bprev;
        ph = prev ? ph + 1 : 1;
      end else if (prev) begin
        acc = !taint && !bprev && !(tf <= n - 1) && !fault_i && ph >= SMIN && ph <= SMAX;
      end
      if (acc) begin
        old_b = cur_b;
        ta = n;
        cur_b[0] = n + FD;
        for (int i = 0; i < 4; i++) begin
          int d;
          d = int'(dur_i[i*DW +: DW]);
          if (d < PMIN) d = PMIN;
          cur_b[i+1] = cur_b[i] + d;
        end
      end
      if (fault_i && tf > n) tf = n;
      prev = print_i;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int ic, io, ix;
      bit ef, es, ee, eb, ew;
      ic = seq_idx(n, cur_b);
      io = seq_idx(n, old_b);
      ix = (ic >= 0) ? ic : io;
      ef = (ix >= 0) && (n < tf);
      es = 0; ee = 0;
      if (ef) begin
        int b[5];
        b = (ic >= 0) ? cur_b : old_b;
        es = (n == b[ix]);
        ee = (n == b[ix+1] - 1);
      end
      eb = !busylow(n);
      ew = !(n >= ta && n < ta + DD && n < tf);
      chk(busy_n_o == eb, "R2/R3/R8/R9 busy_n_o", busy_n_o, eb);
      chk(data_win_o == ew, "R4 data_win_o", data_win_o, ew);
      chk(fire_o == ef, "R5/R6/R9 fire_o", fire_o, ef);
      if (ef) chk(int'(pulse_idx_o) == ix, "R5 pulse_idx_o", pulse_idx_o, ix);
      chk(pulse_start_o == es, "R7 pulse_start_o", pulse_start_o, es);
      chk(pulse_end_o == ee, "R7 pulse_end_o", pulse_end_o, ee);
    end
  end

  task automatic strobe(int w);
    print_i = 1'b1;
    repeat (w) @(negedge clk);
    print_i = 1'b0;
  endtask

  task automatic set_dur(int d0, int d1, int d2, int d3);
    dur_i = {DW'(d3), DW'(d2), DW'(d1), DW'(d0)};
  endtask

  task automatic finish_run();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  task automatic check_idle(string tag);
    chk(busy_n_o == 1'b1, tag, busy_n_o, 1);
    chk(data_win_o == 1'b1, tag, data_win_o, 1);
    chk(fire_o == 1'b0, tag, fire_o, 0);
    chk(pulse_start_o == 1'b0 && pulse_end_o == 1'b0, tag, pulse_start_o | pulse_end_o, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 after reset");
    set_dur(10, 12, 8, 9);
    strobe(1); repeat (4) @(negedge clk);
    chk(busy_n_o == 1'b1, "R2 short strobe ignored", busy_n_o, 1);
    strobe(7); repeat (4) @(negedge clk);
    chk(busy_n_o == 1'b1, "R2 long strobe ignored", busy_n_o, 1);
    strobe(3); @(negedge clk);
    chk(busy_n_o == 1'b0, "R2 valid strobe accepted", busy_n_o, 0);
    repeat (5) @(negedge clk);
    strobe(2);                                  // R3: during busy
    while (!busy_n_o) @(negedge clk);
    set_dur(3, 8, 20, 0);                       // R6 clamp, R8 overlap
    strobe(2);
    while (!(fire_o && pulse_idx_o == 2'd3)) @(negedge clk);
    strobe(6);                                  // R3: begins while busy
    repeat (80) @(negedge clk);
    set_dur(9, 9, 9, 9);
    strobe(SMAX);
    while (!(fire_o && pulse_idx_o == 2'd1)) @(negedge clk);
    fault_i = 1'b1; @(negedge clk); fault_i = 1'b0;
    repeat (10) @(negedge clk);
    strobe(3); repeat (30) @(negedge clk);
    chk(busy_n_o == 1'b0 && fire_o == 1'b0, "R9 locked after fault", {busy_n_o, fire_o}, 0);
    rst_n = 1'b0; repeat (2) @(negedge clk);
    check_idle("R1 second reset");
    rst_n = 1'b1; @(negedge clk);
    set_dur(0, 0, 0, 0);
    strobe(SMIN);
    repeat (90) @(negedge clk);
    check_idle("R8 back to idle");
    finish_run();
  end
endmodule